// File: doc/BRIEF.md
# Flash command sequencer

This block is the command front end of a boot-sector flash interface. It takes write events (an address and a data byte per event) and decodes the multi-write unlock and command sequences that start autoselect, program and erase operations. It tracks the operating mode of the device: reading the array, autoselect, program busy, erase busy, erase suspended, program nested inside an erase suspend, and a latched error state. For every read address it tells the data path whether the array, the status byte or the identification data must be returned.

Two small embedded-algorithm timer models stand in for the real program and erase algorithms. One serves programs and the other serves erases. The sequencer starts them, freezes the erase timer while an erase is suspended, and reacts to their completion and error flags. A supply-good input models the low-supply lockout. While it is low, all command state is cleared and writes have no effect.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the mode is read-array (`mode_o` = 0), `susp_mask_o` is 0 and every read address gives `rd_src_o` = 0 (array). No command is needed.
- R2: An unlock is 0xAA written where address bits [10:0] equal 0x555, then 0x55 where bits [10:0] equal 0x2AA. A third write of 0x90 at 0x555 enters autoselect (`mode_o` = 1), where reads give `rd_src_o` = 2 (identification).
- R3: An unlock followed by 0xA0 at 0x555 arms a program. The next write, at any address, starts it: `mode_o` = 2 for exactly PROG_CYC cycles with status reads (`rd_src_o` = 1), then read-array returns by itself.
- R4: An unlock, 0x80 at 0x555 and a second unlock arm an erase. Then 0x30 at any address starts a sector erase, with the sector taken from the top 3 address bits and marked as a single set bit in `susp_mask_o`. Instead, 0x10 at 0x555 starts a chip erase with all 8 mask bits set. `mode_o` = 3 lasts ERASE_CYC cycles, after which the mode is read-array and the mask is 0.
- R5: A wrong address, a wrong data value or a wrong order inside a sequence drops the partial sequence. The mode stays read-array, or erase-suspended if the sequence began there, and no operation starts.
- R6: 0xF0 at any address returns autoselect and the error state to read-array. The same write is ignored while a program or erase is busy.
- R7: 0xB0 at any address during an erase enters erase-suspend (`mode_o` = 4) and freezes the remaining erase time. Reads there whose top 3 address bits select a set mask bit give status, and all others give array. 0xB0 in any other mode has no effect.
- R8: 0x30 at any address while erase-suspended resumes the erase (`mode_o` = 3). The erase then runs for exactly the cycles it had left.
- R9: While erase-suspended, an unlock plus 0xA0 plus one write starts a nested program (`mode_o` = 5) with status reads at every address. After PROG_CYC cycles the mode returns to 4 with the mask unchanged.
- R10: The fail flag, asserted while a program or erase timer is running, moves the mode to error (`mode_o` = 6). In that mode all reads give status, writes other than 0xF0 are ignored, and 0xF0 leads to read-array with the mask cleared.
- R11: While `vcc_ok_i` is low the mode is forced to read-array, the mask and any running operation are cleared, and writes are ignored.
- R12: The mode code on `mode_o` is 0 read-array, 1 autoselect, 2 program, 3 erase, 4 erase-suspended, 5 program in suspend, 6 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_ok_i | input | 1 | Supply above lockout level |
| wr_en_i | input | 1 | Write event strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| fail_i | input | 1 | Embedded algorithm failure flag (models a timeout) |
| rd_addr_i | input | ADDR_W | Current read address |
| rd_src_o | output | 2 | Read source: 0 array, 1 status, 2 identification |
| mode_o | output | 3 | Operating mode code (see R12) |
| susp_mask_o | output | 8 | Sectors affected by the current or suspended erase |

## Verification
The assertions assume that every write is a single-cycle strobe, already resolved from the bus pins. They also assume that `fail_i` matters only while a timer is running and that supply loss can arrive at any cycle. The stimulus holds each write for exactly one clock. It pulses `fail_i` only during a running program, and drops `vcc_ok_i` only for whole cycles in the middle of an erase. Reads are purely combinational in mode and address, so the bench sets the read address away from the clock edge and samples the read source a short delay later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_AUTOSEL = 3'd1,
    M_PROG    = 3'd2,
    M_ERASE   = 3'd3,
    M_SUSP    = 3'd4,
    M_SPROG   = 3'd5,
    M_ERR     = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_U1,
    S_U2,
    S_PGM,
    S_E0,
    S_E1,
    S_E2
  } seq_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_ID     = 2'd2
  } rd_src_e;

  localparam int unsigned UNLK_W = 11;
  localparam logic [UNLK_W-1:0] ADDR_U1 = 11'h555;
  localparam logic [UNLK_W-1:0] ADDR_U2 = 11'h2AA;

  localparam logic [7:0] CMD_UNLK1   = 8'hAA;
  localparam logic [7:0] CMD_UNLK2   = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERSETUP = 8'h80;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  localparam int unsigned N_ALGO     = 2;
  localparam int unsigned ALGO_PROG  = 0;
  localparam int unsigned ALGO_ERASE = 1;

endpackage

// File: rtl/flash_algo_timer.sv
module flash_algo_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             pause_i,
  input  logic             clr_i,
  input  logic             fail_i,
  output logic             done_o,
  output logic             err_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active = (cnt_q != '0) && !pause_i;
  assign err_o  = active && fail_i;
  assign done_o = active && !fail_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (start_i)  cnt_q <= len_i;
    else if (err_o)    cnt_q <= '0;
    else if (active)   cnt_q <= cnt_q - 1'b1;
  end

  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i && !clr_i && !start_i |=> $stable(cnt_q));

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> cnt_q == '0);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned SEC_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vcc_ok_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [7:0]              wr_data_i,
  input  logic [N_ALGO-1:0]       done_i,
  input  logic [N_ALGO-1:0]       err_i,
  output mode_e                   mode_o,
  output logic [(1<<SEC_W)-1:0]   mask_o,
  output logic [N_ALGO-1:0]       start_o,
  output logic [N_ALGO-1:0]       pause_o,
  output logic                    clr_o
);

  localparam int unsigned N_SEC = 1 << SEC_W;

  mode_e             mode_q, mode_d;
  seq_e              seq_q, seq_d;
  logic [N_SEC-1:0]  mask_q, mask_d;

  logic              wr;
  logic [UNLK_W-1:0] lo_addr;
  logic [SEC_W-1:0]  sec;
  logic              is_u1, is_u2, at_u1, any_err;

  assign wr      = wr_en_i && vcc_ok_i;
  assign lo_addr = wr_addr_i[UNLK_W-1:0];
  assign sec     = wr_addr_i[ADDR_W-1 -: SEC_W];
  assign at_u1   = (lo_addr == ADDR_U1);
  assign is_u1   = wr && at_u1 && (wr_data_i == CMD_UNLK1);
  assign is_u2   = wr && (lo_addr == ADDR_U2) && (wr_data_i == CMD_UNLK2);
  assign any_err = |err_i;

  assign clr_o = !vcc_ok_i || any_err;

  always_comb begin
    pause_o             = '0;
    pause_o[ALGO_ERASE] = (mode_q == M_SUSP) || (mode_q == M_SPROG);
  end

  always_comb begin
    mode_d  = mode_q;
    seq_d   = S_IDLE;
    mask_d  = mask_q;
    start_o = '0;
    if (!vcc_ok_i) begin
      mode_d = M_READ;
      mask_d = '0;
    end else begin
      unique case (mode_q)
        M_PROG: begin
          if (any_err)                 mode_d = M_ERR;
          else if (done_i[ALGO_PROG])  mode_d = M_READ;
        end
        M_SPROG: begin
          if (any_err)                 mode_d = M_ERR;
          else if (done_i[ALGO_PROG])  mode_d = M_SUSP;
        end
        M_ERASE: begin
          if (any_err) mode_d = M_ERR;
          else if (done_i[ALGO_ERASE]) begin
            mode_d = M_READ;
            mask_d = '0;
          end else if (wr && wr_data_i == CMD_SUSP) begin
            mode_d = M_SUSP;
          end
        end
        M_AUTOSEL, M_ERR: begin
          if (wr && wr_data_i == CMD_RESET) begin
            mode_d = M_READ;
            mask_d = '0;
          end
        end
        default: begin  // read-array or erase-suspended: sequence decode
          if (!wr) seq_d = seq_q;
          else begin
            unique case (seq_q)
              S_IDLE: begin
                if (is_u1) seq_d = S_U1;
                else if (mode_q == M_SUSP && wr_data_i == CMD_RESUME)
                  mode_d = M_ERASE;
              end
              S_U1: if (is_u2) seq_d = S_U2;
              S_U2: begin
                if (at_u1) begin
                  if (wr_data_i == CMD_PROG) seq_d = S_PGM;
                  else if (mode_q == M_READ && wr_data_i == CMD_AUTOSEL)
                    mode_d = M_AUTOSEL;
                  else if (mode_q == M_READ && wr_data_i == CMD_ERSETUP)
                    seq_d = S_E0;
                end
              end
              S_PGM: begin
                start_o[ALGO_PROG] = 1'b1;
                mode_d = (mode_q == M_SUSP) ? M_SPROG : M_PROG;
              end
              S_E0: if (is_u1) seq_d = S_E1;
              S_E1: if (is_u2) seq_d = S_E2;
              S_E2: begin
                if (at_u1 && wr_data_i == CMD_CHIP) begin
                  start_o[ALGO_ERASE] = 1'b1;
                  mode_d = M_ERASE;
                  mask_d = '1;
                end else if (wr_data_i == CMD_SECT) begin
                  start_o[ALGO_ERASE] = 1'b1;
                  mode_d = M_ERASE;
                  mask_d = N_SEC'(1) << sec;
                end
              end
              default: seq_d = S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_READ;
      seq_q  <= S_IDLE;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
      mask_q <= mask_d;
    end
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;

  // R11
  lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> mode_q == M_READ && mask_q == '0);

  // R3
  prog_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_ok_i && mode_q == M_PROG && done_i[ALGO_PROG] && !any_err |=> mode_q == M_READ);

  // R9
  nested_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_ok_i && mode_q == M_SPROG && done_i[ALGO_PROG] && !any_err |=> mode_q == M_SUSP && $stable(mask_q));

  // R6
  busy_reset_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_ok_i && (mode_q == M_PROG || mode_q == M_ERASE) && wr_en_i && wr_data_i == CMD_RESET
      && done_i == '0 && !any_err |=> $stable(mode_q));

  // R7
  susp_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SUSP || mode_q == M_SPROG) |-> mask_q != '0);

  // R10
  err_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_ok_i && any_err |=> mode_q == M_ERR);

endmodule

// File: rtl/flash_rd_sel.sv
module flash_rd_sel
  import flash_cmd_pkg::*;
#(
  parameter int unsigned SEC_W = 3
) (
  input  mode_e                 mode_i,
  input  logic [(1<<SEC_W)-1:0] mask_i,
  input  logic [SEC_W-1:0]      rd_sec_i,
  output rd_src_e               rd_src_o
);

  always_comb begin
    unique case (mode_i)
      M_READ:    rd_src_o = RD_ARRAY;
      M_AUTOSEL: rd_src_o = RD_ID;
      M_SUSP:    rd_src_o = mask_i[rd_sec_i] ? RD_STATUS : RD_ARRAY;
      default:   rd_src_o = RD_STATUS;
    endcase
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned SEC_W     = 3,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned ERASE_CYC = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vcc_ok_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  fail_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [1:0]            rd_src_o,
  output logic [2:0]            mode_o,
  output logic [(1<<SEC_W)-1:0] susp_mask_o
);

  localparam int unsigned N_SEC   = 1 << SEC_W;
  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  mode_e             mode;
  rd_src_e           rd_src;
  logic [N_SEC-1:0]  mask;
  logic [N_ALGO-1:0] start, pause, done, err;
  logic              clr;

  flash_cmd_ctrl #(
    .ADDR_W (ADDR_W),
    .SEC_W  (SEC_W)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vcc_ok_i  (vcc_ok_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .done_i    (done),
    .err_i     (err),
    .mode_o    (mode),
    .mask_o    (mask),
    .start_o   (start),
    .pause_o   (pause),
    .clr_o     (clr)
  );

  for (genvar g = 0; g < N_ALGO; g++) begin : g_algo
    localparam logic [CNT_W-1:0] LEN = (g == ALGO_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
    flash_algo_timer #(
      .CNT_W (CNT_W)
    ) i_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start[g]),
      .len_i   (LEN),
      .pause_i (pause[g]),
      .clr_i   (clr),
      .fail_i  (fail_i),
      .done_o  (done[g]),
      .err_o   (err[g])
    );
  end

  flash_rd_sel #(
    .SEC_W (SEC_W)
  ) i_rd_sel (
    .mode_i   (mode),
    .mask_i   (mask),
    .rd_sec_i (rd_addr_i[ADDR_W-1 -: SEC_W]),
    .rd_src_o (rd_src)
  );

  assign mode_o      = mode;
  assign rd_src_o    = rd_src;
  assign susp_mask_o = mask;

endmodule

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;

  localparam int unsigned ADDR_W    = 17;
  localparam int unsigned PROG_CYC  = 8;
  localparam int unsigned ERASE_CYC = 40;
  localparam int unsigned VW        = 33;
  localparam int unsigned NV        = 26;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              vcc_ok = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              fail = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [1:0]        rd_src;
  logic [2:0]        mode;
  logic [7:0]        mask;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_fsm #(
    .ADDR_W    (ADDR_W),
    .SEC_W     (3),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) i_flash_cmd_fsm (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .vcc_ok_i    (vcc_ok),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .fail_i      (fail),
    .rd_addr_i   (rd_addr),
    .rd_src_o    (rd_src),
    .mode_o      (mode),
    .susp_mask_o (mask)
  );

  // {req[3:0], wr, addr[16:0], data[7:0], expected mode[2:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  1'b1, 17'h00555, 8'hAA, 3'd0},
    {4'd2,  1'b1, 17'h002AA, 8'h55, 3'd0},
    {4'd2,  1'b1, 17'h00555, 8'h90, 3'd1},  // R2 autoselect
    {4'd6,  1'b1, 17'h00555, 8'hA0, 3'd1},  // R6 other writes ignored
    {4'd6,  1'b1, 17'h01234, 8'hF0, 3'd0},  // R6 reset leaves autoselect
    {4'd5,  1'b1, 17'h00555, 8'hAA, 3'd0},
    {4'd5,  1'b1, 17'h002AB, 8'h55, 3'd0},  // R5 wrong address
    {4'd5,  1'b1, 17'h00555, 8'hA0, 3'd0},
    {4'd5,  1'b1, 17'h00000, 8'h00, 3'd0},  // no program started
    {4'd5,  1'b1, 17'h00555, 8'hAA, 3'd0},
    {4'd5,  1'b1, 17'h002AA, 8'h56, 3'd0},  // R5 wrong data
    {4'd5,  1'b1, 17'h00555, 8'h90, 3'd0},
    {4'd5,  1'b1, 17'h002AA, 8'h55, 3'd0},  // R5 wrong order
    {4'd5,  1'b1, 17'h00555, 8'hAA, 3'd0},
    {4'd5,  1'b1, 17'h00555, 8'hA0, 3'd0},
    {4'd5,  1'b1, 17'h00010, 8'h11, 3'd0},
    {4'd5,  1'b1, 17'h00555, 8'hAA, 3'd0},
    {4'd5,  1'b1, 17'h002AA, 8'h55, 3'd0},
    {4'd5,  1'b1, 17'h00555, 8'h80, 3'd0},
    {4'd5,  1'b1, 17'h00555, 8'hAA, 3'd0},
    {4'd5,  1'b1, 17'h002AA, 8'h55, 3'd0},
    {4'd5,  1'b1, 17'h00555, 8'h55, 3'd0},  // R5 bad erase confirm
    {4'd5,  1'b1, 17'h00000, 8'h30, 3'd0},
    {4'd2,  1'b1, 17'h1F555, 8'hAA, 3'd0},  // R2 only low 11 bits decoded
    {4'd2,  1'b1, 17'h0AAAA, 8'h55, 3'd0},
    {4'd12, 1'b1, 17'h08555, 8'h90, 3'd1}
  };

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic unlock();
    wr(17'h00555, 8'hAA);
    wr(17'h002AA, 8'h55);
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input int exp);
    rd_addr = a;
    #1;
    chk(tag, "rd_src", int'(rd_src), exp);
  endtask

  task automatic wait_leave(input logic [2:0] m, output int n);
    n = 0;
    while (mode == m && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mode in reset", int'(mode), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "mask", int'(mask), 0);
    rd_chk("R1", 17'h1ABCD, 0);

    for (int i = 0; i < int'(NV); i++) begin
      logic [VW-1:0] v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d", v[32:29]);
      if (v[28]) wr(v[27:11], v[10:3]);
      else @(negedge clk);
      chk(t, $sformatf("vector %0d mode", i), int'(mode), int'(v[2:0]));
    end
    rd_chk("R2", 17'h00001, 2);
    wr(17'h00000, 8'hF0);
    chk("R6", "reset from autoselect", int'(mode), 0);

    // R3 program timing and automatic return
    unlock();
    wr(17'h00555, 8'hA0);
    chk("R3", "armed, not busy", int'(mode), 0);
    wr(17'h00123, 8'h5A);
    chk("R3", "program mode", int'(mode), 2);
    rd_chk("R3", 17'h00123, 1);
    wait_leave(3'd2, n);
    chk("R3", "program cycles", n, PROG_CYC);
    chk("R3", "back to read", int'(mode), 0);
    rd_chk("R3", 17'h00123, 0);

    // R6 reset ignored while program busy
    unlock();
    wr(17'h00555, 8'hA0);
    wr(17'h00040, 8'h01);
    wr(17'h00000, 8'hF0);
    chk("R6", "F0 ignored in program", int'(mode), 2);
    wait_leave(3'd2, n);
    chk("R6", "program finishes", int'(mode), 0);

    // R4 chip erase
    unlock();
    wr(17'h00555, 8'h80);
    unlock();
    wr(17'h00555, 8'h10);
    chk("R4", "chip erase mode", int'(mode), 3);
    chk("R4", "chip erase mask", int'(mask), 8'hFF);
    wait_leave(3'd3, n);
    chk("R4", "erase cycles", n, ERASE_CYC);
    chk("R4", "mask cleared", int'(mask), 0);

    // R7 sector erase, suspend, reads
    unlock();
    wr(17'h00555, 8'h80);
    unlock();
    wr(17'h14000, 8'h30);
    chk("R4", "sector mask", int'(mask), 8'h20);
    repeat (10) @(negedge clk);
    wr(17'h00007, 8'hB0);
    chk("R7", "suspended", int'(mode), 4);
    rd_chk("R7", 17'h14ABC, 1);
    rd_chk("R7", 17'h00ABC, 0);
    rd_chk("R7", 17'h1FFFF, 0);
    wr(17'h00000, 8'hB0);
    chk("R7", "second B0 ignored", int'(mode), 4);
    unlock();
    wr(17'h002AA, 8'h00);
    chk("R5", "abort in suspend", int'(mode), 4);

    // R9 nested program
    unlock();
    wr(17'h00555, 8'hA0);
    wr(17'h02000, 8'h11);
    chk("R9", "nested program", int'(mode), 5);
    rd_chk("R9", 17'h00000, 1);
    wait_leave(3'd5, n);
    chk("R9", "nested cycles", n, PROG_CYC);
    chk("R9", "back to suspend", int'(mode), 4);
    chk("R9", "mask kept", int'(mask), 8'h20);
    rd_chk("R9", 17'h15000, 1);
    rd_chk("R9", 17'h02000, 0);

    // R8 resume with remaining time
    wr(17'h07777, 8'h30);
    chk("R8", "resumed", int'(mode), 3);
    wait_leave(3'd3, n);
    chk("R8", "remaining cycles", n, ERASE_CYC - 11);
    chk("R8", "mask cleared", int'(mask), 0);
    wr(17'h00000, 8'hB0);
    chk("R7", "B0 in read ignored", int'(mode), 0);

    // R10 failure during program
    unlock();
    wr(17'h00555, 8'hA0);
    wr(17'h00100, 8'h22);
    @(negedge clk);
    fail = 1'b1;
    @(negedge clk);
    fail = 1'b0;
    chk("R10", "error mode", int'(mode), 6);
    rd_chk("R10", 17'h1C000, 1);
    wr(17'h00555, 8'hAA);
    chk("R10", "writes ignored", int'(mode), 6);
    repeat (PROG_CYC) @(negedge clk);
    chk("R10", "still error", int'(mode), 6);
    wr(17'h00321, 8'hF0);
    chk("R10", "reset clears error", int'(mode), 0);
    chk("R12", "read code", int'(mode), 0);

    // R11 supply lockout during erase
    unlock();
    wr(17'h00555, 8'h80);
    unlock();
    wr(17'h0C000, 8'h30);
    repeat (3) @(negedge clk);
    vcc_ok = 1'b0;
    @(negedge clk);
    chk("R11", "lockout mode", int'(mode), 0);
    chk("R11", "lockout mask", int'(mask), 0);
    wr(17'h00555, 8'hAA);
    vcc_ok = 1'b1;
    wr(17'h002AA, 8'h55);
    wr(17'h00555, 8'hA0);
    wr(17'h00000, 8'h00);
    chk("R11", "write during lockout dropped", int'(mode), 0);
    repeat (ERASE_CYC) @(negedge clk);
    chk("R11", "erase cancelled", int'(mode), 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule